// File: doc/BRIEF.md
# Peripheral Interrupt Aggregation Latch

This block collects interrupt conditions from five on-chip peripherals (three DMA channels, an application accelerator and a performance monitor) and presents them as one active-low, level-sensitive fast-interrupt request to a processor. Each DMA channel and the accelerator offer two completion conditions, a chain-done and a transfer-done flag. The performance monitor offers one overflow flag per event counter plus one for the global timestamp counter.

Each source's conditions are ORed together and registered into one latch bit per source. The latch is not cleared by software. A bit falls only after its peripheral withdraws every condition behind it. The output line is a registered reduction of the latch, so it carries no glitches. Software sees the latch through a read-only 32-bit status word on a simple read port, and writes to that port change nothing.

Top module: `irq_aggr_latch`

## Requirements
- R1: A synchronous active-high reset clears every latch bit, and the output `fiq_n` reads 1 (inactive) in the first cycle after reset.
- R2: The latch bit of DMA channel k (k = 0..2) is 1 in the cycle after either its chain-done or its transfer-done condition is high, and is 0 in the cycle after both are low.
- R3: The accelerator latch bit follows the OR of its chain-done and transfer-done conditions, with one cycle of delay.
- R4: The performance-monitor latch bit is 1 one cycle after any event-counter overflow bit or the timestamp overflow is high, and is 0 one cycle after all of them are low.
- R5: `fiq_n` is 0 exactly in the cycle after the latch holds at least one set bit, and 1 otherwise. It therefore trails a condition by two clock edges.
- R6: The status read returns DMA channel 0..2 in bits 0..2, the accelerator in bit 3, the performance monitor in bit 4, and zero in bits 31..5. The data is combinational from the latch.
- R7: A write strobe with any data leaves the latch, the status word and `fiq_n` unchanged.
- R8: While any one condition of a source stays high, that source's bit stays 1, even in the cycle when another of its conditions falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_chain_done | input | 3 | Chain-done condition per DMA channel |
| dma_xfer_done | input | 3 | Transfer-done condition per DMA channel |
| acc_chain_done | input | 1 | Accelerator chain-done condition |
| acc_xfer_done | input | 1 | Accelerator transfer-done condition |
| pmu_cnt_ovf | input | 14 | Overflow pending per event counter |
| pmu_ts_ovf | input | 1 | Global timestamp counter overflow pending |
| rd_en | input | 1 | Status read strobe |
| wr_en | input | 1 | Write strobe (ignored) |
| wr_data | input | 32 | Write data (ignored) |
| rd_data | output | 32 | Status word |
| fiq_n | output | 1 | Active-low level fast-interrupt request |

## Verification
The bench uses the default configuration of three DMA channels and fourteen event counters. Because the accelerator and DMA conditions together have only eight input bits, every one of the 256 patterns is applied. Each pattern is checked against an expected status word and interrupt level computed in the bench. Each of the fifteen monitor overflow inputs is also applied on its own, which makes the single-bit corners of the performance-monitor OR reachable. Handover sequences between a source's two conditions, and writes with varied data, cover the hold and ignore rules.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
    localparam int unsigned NUM_DMA      = 3;
    localparam int unsigned NUM_SRC      = NUM_DMA + 2;
    localparam int unsigned REG_W        = 32;
    localparam int unsigned ACC_BIT      = NUM_DMA;
    localparam int unsigned PMU_BIT      = NUM_DMA + 1;

    typedef struct packed {
        logic chain_done;
        logic xfer_done;
    } done_pair_t;

    typedef logic [NUM_SRC-1:0] latch_vec_t;

    function automatic logic pair_req(done_pair_t p);
        return p.chain_done | p.xfer_done;
    endfunction

    function automatic logic [REG_W-1:0] status_word(latch_vec_t l);
        logic [REG_W-1:0] w;
        w = '0;
        w[NUM_SRC-1:0] = l;
        return w;
    endfunction
endpackage

// File: rtl/irq_src_combine.sv
module irq_src_combine
    import irq_aggr_pkg::*;
#(
    parameter int unsigned PMU_CNT = 14
) (
    input  logic [NUM_DMA-1:0] dma_chain_done,
    input  logic [NUM_DMA-1:0] dma_xfer_done,
    input  logic               acc_chain_done,
    input  logic               acc_xfer_done,
    input  logic [PMU_CNT-1:0] pmu_cnt_ovf,
    input  logic               pmu_ts_ovf,
    output latch_vec_t         req
);
    done_pair_t acc_pair;

    for (genvar k = 0; k < NUM_DMA; k++) begin : g_dma
        done_pair_t pair;
        assign pair.chain_done = dma_chain_done[k];
        assign pair.xfer_done  = dma_xfer_done[k];
        assign req[k] = pair_req(pair);
    end

    assign acc_pair.chain_done = acc_chain_done;
    assign acc_pair.xfer_done  = acc_xfer_done;
    assign req[ACC_BIT] = pair_req(acc_pair);
    assign req[PMU_BIT] = (|pmu_cnt_ovf) | pmu_ts_ovf;
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
    import irq_aggr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  latch_vec_t req,
    output latch_vec_t lat,
    output logic       fiq_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat   <= '0;
            fiq_n <= 1'b1;
        end else begin
            lat   <= req;
            fiq_n <= ~(|lat);
        end
    end
endmodule

// File: rtl/irq_aggr_latch.sv
module irq_aggr_latch
    import irq_aggr_pkg::*;
#(
    parameter int unsigned PMU_CNT = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DMA-1:0] dma_chain_done,
    input  logic [NUM_DMA-1:0] dma_xfer_done,
    input  logic               acc_chain_done,
    input  logic               acc_xfer_done,
    input  logic [PMU_CNT-1:0] pmu_cnt_ovf,
    input  logic               pmu_ts_ovf,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic               fiq_n
);
    latch_vec_t req;
    latch_vec_t lat;
    logic       unused_wr;

    assign unused_wr = wr_en ^ (^wr_data);

    irq_src_combine #(.PMU_CNT(PMU_CNT)) u_comb (
        .dma_chain_done(dma_chain_done),
        .dma_xfer_done (dma_xfer_done),
        .acc_chain_done(acc_chain_done),
        .acc_xfer_done (acc_xfer_done),
        .pmu_cnt_ovf   (pmu_cnt_ovf),
        .pmu_ts_ovf    (pmu_ts_ovf),
        .req           (req)
    );

    irq_latch_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .lat  (lat),
        .fiq_n(fiq_n)
    );

    assign rd_data = rd_en ? status_word(lat) : '0;
endmodule

// File: rtl/irq_aggr_latch_chk.sv
module irq_aggr_latch_chk
    import irq_aggr_pkg::*;
#(
    parameter int unsigned PMU_CNT = 14
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_DMA-1:0] dma_chain_done,
    input logic [NUM_DMA-1:0] dma_xfer_done,
    input logic               acc_chain_done,
    input logic               acc_xfer_done,
    input logic [PMU_CNT-1:0] pmu_cnt_ovf,
    input logic               pmu_ts_ovf,
    input logic               rd_en,
    input logic [REG_W-1:0]   rd_data,
    input logic               fiq_n
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> fiq_n); // R1
    AST_DMA0_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rd_data[0] == $past(dma_chain_done[0] | dma_xfer_done[0])); // R2
    AST_ACC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rd_data[ACC_BIT] == $past(acc_chain_done | acc_xfer_done)); // R3
    AST_PMU_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rd_data[PMU_BIT] == $past((|pmu_cnt_ovf) | pmu_ts_ovf)); // R4
    AST_UPPER_ZERO: assert property (@(posedge clk)
        rd_data[REG_W-1:NUM_SRC] == '0); // R6
    AST_HOLD_ACC: assert property (@(posedge clk) disable iff (rst)
        (acc_chain_done && acc_xfer_done) ##1 (acc_chain_done ^ acc_xfer_done)
        |=> (rd_en |-> rd_data[ACC_BIT])); // R8
endmodule

bind irq_aggr_latch irq_aggr_latch_chk #(.PMU_CNT(PMU_CNT)) u_chk (
    .clk(clk), .rst(rst),
    .dma_chain_done(dma_chain_done), .dma_xfer_done(dma_xfer_done),
    .acc_chain_done(acc_chain_done), .acc_xfer_done(acc_xfer_done),
    .pmu_cnt_ovf(pmu_cnt_ovf), .pmu_ts_ovf(pmu_ts_ovf),
    .rd_en(rd_en), .rd_data(rd_data), .fiq_n(fiq_n)
);

// File: tb/irq_aggr_latch_bench.sv
`timescale 1ns/1ps
module irq_aggr_latch_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  dma_chain_done = '0;
    logic [2:0]  dma_xfer_done = '0;
    logic        acc_chain_done = 1'b0;
    logic        acc_xfer_done = 1'b0;
    logic [13:0] pmu_cnt_ovf = '0;
    logic        pmu_ts_ovf = 1'b0;
    logic        rd_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        fiq_n;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_aggr_latch u_irq_aggr_latch (
        .clk(clk), .rst(rst),
        .dma_chain_done(dma_chain_done), .dma_xfer_done(dma_xfer_done),
        .acc_chain_done(acc_chain_done), .acc_xfer_done(acc_xfer_done),
        .pmu_cnt_ovf(pmu_cnt_ovf), .pmu_ts_ovf(pmu_ts_ovf),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .fiq_n(fiq_n)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(logic [2:0] c, logic [2:0] x,
                                             logic ac, logic ax, logic pm);
        return {27'd0, pm, ac | ax, c | x};
    endfunction

    initial begin
        logic [31:0] e;
        tick(2);
        chk("R1 status", rd_data, 32'd0);
        chk("R1 fiq_n", {31'd0, fiq_n}, 32'd1);
        rst = 1'b0;
        tick(1);
        // R2 R3 R5 R6: full sweep of DMA and accelerator conditions
        for (int p = 0; p < 256; p++) begin
            dma_chain_done = p[2:0]; dma_xfer_done = p[5:3];
            acc_chain_done = p[6];   acc_xfer_done = p[7];
            e = exp_word(p[2:0], p[5:3], p[6], p[7], 1'b0);
            tick(1);
            chk("R2/R3/R6 status", rd_data, e);
            tick(1);
            chk("R5 fiq_n", {31'd0, fiq_n}, {31'd0, ~(|e)});
        end
        dma_chain_done = '0; dma_xfer_done = '0;
        acc_chain_done = 0; acc_xfer_done = 0;
        tick(2);
        chk("R2 clear", rd_data, 32'd0);
        chk("R5 idle", {31'd0, fiq_n}, 32'd1);
        // R4: each monitor overflow input alone
        for (int i = 0; i < 15; i++) begin
            if (i < 14) pmu_cnt_ovf = 14'(1) << i; else pmu_ts_ovf = 1'b1;
            tick(1);
            chk("R4 set", rd_data, 32'h10);
            pmu_cnt_ovf = '0; pmu_ts_ovf = 1'b0;
            tick(1);
            chk("R4 clear", rd_data, 32'h0);
        end
        // R8: handover chain-done -> transfer-done on DMA1 and accelerator
        dma_chain_done[1] = 1; acc_chain_done = 1;
        tick(1);
        dma_xfer_done[1] = 1; acc_xfer_done = 1;
        tick(1);
        dma_chain_done[1] = 0; acc_chain_done = 0;
        tick(1);
        chk("R8 hold", rd_data, 32'h0A);
        chk("R8 fiq_n", {31'd0, fiq_n}, 32'd0);
        // R7: writes during set state change nothing
        for (int w = 0; w < 8; w++) begin
            wr_en = 1; wr_data = 32'hFFFF_FFFF >> (w * 4);
            tick(1);
            chk("R7 write set", rd_data, 32'h0A);
            chk("R7 fiq_n", {31'd0, fiq_n}, 32'd0);
        end
        wr_en = 0;
        dma_xfer_done[1] = 0; acc_xfer_done = 0;
        tick(1);
        chk("R8 release", rd_data, 32'h0);
        tick(1);
        wr_en = 1; wr_data = 32'h1F;
        tick(2);
        chk("R7 write idle", rd_data, 32'h0);
        chk("R7 idle fiq_n", {31'd0, fiq_n}, 32'd1);
        wr_en = 0;
        // R1: reset while active
        pmu_ts_ovf = 1;
        tick(3);
        rst = 1;
        tick(1);
        chk("R1 mid reset status", rd_data, 32'h0);
        chk("R1 mid reset fiq_n", {31'd0, fiq_n}, 32'd1);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                mismatched++; compared++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule